// File: doc/BRIEF.md
# Instruction Address Translator with Set-Associative TLB

This block turns instruction fetch addresses into physical addresses through a set-associative translation table of one to four ways. Each table entry has two words. The tag word holds the page tag, a valid flag and an age counter. The mapping word holds the physical page, a no-cache flag and two execute permissions, one for supervisor mode and one for user mode. A fetch request picks a set from the low page-number bits and compares the tag in every way of that set. The block then returns one of three results: a translated address with its no-cache flag, a miss, or a page fault. When the mode inputs switch translation off, the address passes through unchanged, and the top address bit alone decides whether the fetch is cacheable.

A combinational probe port runs the same lookup for debug use. It never changes any state. Software loads and reads entries through a small register port, and a constant output reports the geometry the block was built with. Table refill and exception dispatch belong to the surrounding core.

The fetch port is controlled by a two-state machine. `ST_IDLE` raises `req_ready`. A valid request in `ST_IDLE` takes the transition to `ST_RESP`, and the block registers the result of the lookup on that edge. `ST_RESP` drives `resp_valid` for one cycle and then always returns to `ST_IDLE`.

Top module: `itlb_xlate`

## Requirements
- R1: When `mmu_en` is 0 or `impl_present` is 0, a fetch returns `resp_paddr` equal to the request address, with no miss and no fault, and `resp_ci` equal to the address's top bit (set when the address is at or above 0x80000000).
- R2: Address bits [PAGE_BITS +: log2(SETS)] select the set. A way's tag is stored in bits [31 : PAGE_BITS+log2(SETS)] of its tag word and is compared with the same bits of the address. An address in another set, or with any differing tag bit, misses.
- R3: A way hits only when bit 0 (valid) of its tag word is 1 and its tag matches. When several ways match, the lowest-numbered way is used.
- R4: On a permitted hit, `resp_paddr` is mapping-word bits [31:PAGE_BITS] followed by the address's page-offset bits, and `resp_ci` is mapping-word bit 0.
- R5: On a translated fetch that hits, the age field of every other way in that set (tag-word bits [6 +: log2(SETS)]) is decremented by one if it is nonzero. The hit way's age is set to SETS-1. Other sets are not changed.
- R6: Permissions are checked on a hit. With `sup_mode`=1, a clear mapping-word bit 1 gives a fault. With `sup_mode`=0, a clear mapping-word bit 2 gives a fault. A faulting response has `resp_fault`=1, `resp_miss`=0, `resp_paddr`=0 and `resp_ci`=0, and `resp_vaddr` holds the fetch address.
- R7: A translated fetch that misses returns `resp_miss`=1, `resp_paddr`=0 and `resp_ci`=0, and changes no table word.
- R8: `probe_paddr` gives the translated address for `probe_addr` in the same cycle. It gives 0 on a miss or a permission failure, and gives `probe_addr` itself when translation is off. A probe changes no age field.
- R9: `req_ready` is 1 in the idle state. After an accepted request, `resp_valid` is 1 for exactly one cycle, in the next cycle, and `req_ready` is 0 during that cycle.
- R10: Register address bit [log2(SETS)+2] selects the word (0 = tag word, 1 = mapping word). The two bits below it select the way, and the low log2(SETS) bits select the set. Writes take effect at the clock edge, and reads are combinational. All words reset to 0. A software write to a tag word overrides an age update to the same word in the same cycle.
- R11: `cfg_info` reports log2(SETS) in bits [5:3] and WAYS-1 in bits [1:0]. This is 0x23 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mmu_en | input | 1 | Translation enable from the status register |
| impl_present | input | 1 | Translation unit present flag |
| sup_mode | input | 1 | 1 = supervisor mode, 0 = user mode |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Fetch virtual address |
| resp_valid | output | 1 | Result valid (one cycle) |
| resp_paddr | output | 32 | Physical address |
| resp_ci | output | 1 | Fetch is not cacheable |
| resp_miss | output | 1 | Table miss |
| resp_fault | output | 1 | Execute-permission fault |
| resp_vaddr | output | 32 | Virtual address of the answered request |
| probe_addr | input | 32 | Debug probe address |
| probe_paddr | output | 32 | Debug probe result |
| reg_wr_en | input | 1 | Table write strobe |
| reg_wr_addr | input | 7 | Table write address |
| reg_wr_data | input | 32 | Table write data |
| reg_rd_addr | input | 7 | Table read address |
| reg_rd_data | output | 32 | Table read data |
| cfg_info | output | 32 | Geometry report |

## Verification
The hardest case to reach is a software write to a tag word landing on the same edge as the age update caused by a hit on that same word. The bench lines this up by raising the write strobe and the fetch request in the same cycle, both aimed at the way that is known to hit. It then reads the word back to confirm that the written value survived, and that the lookup itself still used the old contents. The age decrement is checked by loading one set with a mix of zero, small and large ages, including an invalid way that still carries an age, and reading every way back after the hit.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } itlb_state_e;

    // tag word fields
    localparam int TAG_VALID_BIT = 0;
    localparam int TAG_AGE_LO    = 6;

    // mapping word fields
    localparam int MAP_NC_BIT    = 0;
    localparam int MAP_SX_BIT    = 1;
    localparam int MAP_UX_BIT    = 2;

endpackage

// File: rtl/itlb_store.sv
module itlb_store
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int PAGE_BITS = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [$clog2(SETS)+2:0]         wr_addr,
    input  logic [ADDR_W-1:0]               wr_data,
    input  logic [$clog2(SETS)+2:0]         rd_addr,
    output logic [ADDR_W-1:0]               rd_data,
    input  logic                            upd_en,
    input  logic [$clog2(SETS)-1:0]         upd_set,
    input  logic [WAYS-1:0]                 upd_oh,
    input  logic [$clog2(SETS)-1:0]         set_a,
    output logic [WAYS-1:0][ADDR_W-1:0]     tag_a,
    output logic [WAYS-1:0][ADDR_W-1:0]     map_a,
    input  logic [$clog2(SETS)-1:0]         set_b,
    output logic [WAYS-1:0][ADDR_W-1:0]     tag_b,
    output logic [WAYS-1:0][ADDR_W-1:0]     map_b
);
    localparam int SET_BITS = $clog2(SETS);
    localparam int AGE_W    = SET_BITS;
    localparam int RA_W     = SET_BITS + 3;

    logic [ADDR_W-1:0] tag_mem [SETS][WAYS];
    logic [ADDR_W-1:0] map_mem [SETS][WAYS];

    logic [SET_BITS-1:0] wr_set, rd_set;
    logic [1:0]          wr_way, rd_way;
    logic                wr_map, rd_map;

    assign wr_set = wr_addr[SET_BITS-1:0];
    assign wr_way = wr_addr[SET_BITS +: 2];
    assign wr_map = wr_addr[RA_W-1];
    assign rd_set = rd_addr[SET_BITS-1:0];
    assign rd_way = rd_addr[SET_BITS +: 2];
    assign rd_map = rd_addr[RA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tag_mem[s][w] <= '0;
                    map_mem[s][w] <= '0;
                end
            end
        end else begin
            if (upd_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (upd_oh[w]) begin
                        tag_mem[upd_set][w][TAG_AGE_LO +: AGE_W] <= '1;
                    end else if (tag_mem[upd_set][w][TAG_AGE_LO +: AGE_W] != '0) begin
                        tag_mem[upd_set][w][TAG_AGE_LO +: AGE_W] <=
                            tag_mem[upd_set][w][TAG_AGE_LO +: AGE_W] - AGE_W'(1);
                    end
                end
            end
            // later assignment: software write wins over the age update
            if (wr_en && (int'(wr_way) < WAYS)) begin
                if (wr_map) map_mem[wr_set][wr_way] <= wr_data;
                else        tag_mem[wr_set][wr_way] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_way) < WAYS) begin
            rd_data = rd_map ? map_mem[rd_set][rd_way] : tag_mem[rd_set][rd_way];
        end
    end

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            tag_a[w] = tag_mem[set_a][w];
            map_a[w] = map_mem[set_a][w];
            tag_b[w] = tag_mem[set_b][w];
            map_b[w] = map_mem[set_b][w];
        end
    end

endmodule

// File: rtl/itlb_match.sv
module itlb_match
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int PAGE_BITS = 13
) (
    input  logic [ADDR_W-PAGE_BITS-$clog2(SETS)-1:0] vpn,
    input  logic [WAYS-1:0][ADDR_W-1:0]              tags,
    input  logic [WAYS-1:0][ADDR_W-1:0]              maps,
    output logic [WAYS-1:0]                          hit_oh,
    output logic [ADDR_W-1:0]                        hit_map
);
    localparam int VPN_LO = PAGE_BITS + $clog2(SETS);

    logic [WAYS-1:0] way_eq;
    logic            unused_tag_bits;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign way_eq[g] = tags[g][TAG_VALID_BIT] &&
                               (tags[g][ADDR_W-1:VPN_LO] == vpn);
        end
    endgenerate

    // lowest-numbered matching way wins
    always_comb begin
        hit_oh  = '0;
        hit_map = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_eq[w]) begin
                hit_oh  = '0;
                hit_oh[w] = 1'b1;
                hit_map = maps[w];
            end
        end
    end

    assign unused_tag_bits = ^tags;

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SETS      = 16,
    parameter int WAYS      = 4,
    parameter int PAGE_BITS = 13
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mmu_en,
    input  logic                      impl_present,
    input  logic                      sup_mode,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [ADDR_W-1:0]         req_addr,
    output logic                      resp_valid,
    output logic [ADDR_W-1:0]         resp_paddr,
    output logic                      resp_ci,
    output logic                      resp_miss,
    output logic                      resp_fault,
    output logic [ADDR_W-1:0]         resp_vaddr,
    input  logic [ADDR_W-1:0]         probe_addr,
    output logic [ADDR_W-1:0]         probe_paddr,
    input  logic                      reg_wr_en,
    input  logic [$clog2(SETS)+2:0]   reg_wr_addr,
    input  logic [ADDR_W-1:0]         reg_wr_data,
    input  logic [$clog2(SETS)+2:0]   reg_rd_addr,
    output logic [ADDR_W-1:0]         reg_rd_data,
    output logic [31:0]               cfg_info
);
    localparam int SET_BITS = $clog2(SETS);
    localparam int VPN_LO   = PAGE_BITS + SET_BITS;
    localparam int VPN_W    = ADDR_W - VPN_LO;
    localparam logic [31:0] GEOMETRY = (32'(SET_BITS) << 3) | 32'(WAYS - 1);

    itlb_state_e state, state_nx;

    logic                       xlate_on;
    logic                       accept;
    logic [SET_BITS-1:0]        f_set, p_set;
    logic [WAYS-1:0][ADDR_W-1:0] f_tags, f_maps, p_tags, p_maps;
    logic [WAYS-1:0]            f_oh, p_oh;
    logic [ADDR_W-1:0]          f_map, p_map;
    logic                       f_hit, p_hit, f_perm, p_perm;

    logic [ADDR_W-1:0] nx_paddr;
    logic              nx_ci, nx_miss, nx_fault;
    logic [ADDR_W-1:0] r_paddr, r_vaddr;
    logic              r_ci, r_miss, r_fault;
    logic              unused_map_bits;

    assign xlate_on = mmu_en && impl_present;
    assign f_set    = req_addr[PAGE_BITS +: SET_BITS];
    assign p_set    = probe_addr[PAGE_BITS +: SET_BITS];
    assign cfg_info = GEOMETRY;

    itlb_store #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PAGE_BITS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data),
        .rd_addr (reg_rd_addr),
        .rd_data (reg_rd_data),
        .upd_en  (accept && xlate_on && f_hit),
        .upd_set (f_set),
        .upd_oh  (f_oh),
        .set_a   (f_set),
        .tag_a   (f_tags),
        .map_a   (f_maps),
        .set_b   (p_set),
        .tag_b   (p_tags),
        .map_b   (p_maps)
    );

    itlb_match #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PAGE_BITS)
    ) u_fetch_match (
        .vpn     (req_addr[ADDR_W-1:VPN_LO]),
        .tags    (f_tags),
        .maps    (f_maps),
        .hit_oh  (f_oh),
        .hit_map (f_map)
    );

    itlb_match #(
        .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS), .PAGE_BITS(PAGE_BITS)
    ) u_probe_match (
        .vpn     (probe_addr[ADDR_W-1:VPN_LO]),
        .tags    (p_tags),
        .maps    (p_maps),
        .hit_oh  (p_oh),
        .hit_map (p_map)
    );

    assign f_hit  = |f_oh;
    assign p_hit  = |p_oh;
    assign f_perm = sup_mode ? f_map[MAP_SX_BIT] : f_map[MAP_UX_BIT];
    assign p_perm = sup_mode ? p_map[MAP_SX_BIT] : p_map[MAP_UX_BIT];

    assign unused_map_bits = ^{f_map, p_map, VPN_W'(0)};

    // fetch lookup result, registered on accept
    always_comb begin
        nx_paddr = '0;
        nx_ci    = 1'b0;
        nx_miss  = 1'b0;
        nx_fault = 1'b0;
        if (!xlate_on) begin
            nx_paddr = req_addr;
            nx_ci    = req_addr[ADDR_W-1];
        end else if (!f_hit) begin
            nx_miss  = 1'b1;
        end else if (!f_perm) begin
            nx_fault = 1'b1;
        end else begin
            nx_paddr = {f_map[ADDR_W-1:PAGE_BITS], req_addr[PAGE_BITS-1:0]};
            nx_ci    = f_map[MAP_NC_BIT];
        end
    end

    // side-effect-free probe
    always_comb begin
        if (!xlate_on)
            probe_paddr = probe_addr;
        else if (p_hit && p_perm)
            probe_paddr = {p_map[ADDR_W-1:PAGE_BITS], probe_addr[PAGE_BITS-1:0]};
        else
            probe_paddr = '0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    assign accept = req_valid && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_paddr <= '0;
            r_vaddr <= '0;
            r_ci    <= 1'b0;
            r_miss  <= 1'b0;
            r_fault <= 1'b0;
        end else if (accept) begin
            r_paddr <= nx_paddr;
            r_vaddr <= req_addr;
            r_ci    <= nx_ci;
            r_miss  <= nx_miss;
            r_fault <= nx_fault;
        end
    end

    // outputs
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        resp_paddr = '0;
        resp_vaddr = '0;
        resp_ci    = 1'b0;
        resp_miss  = 1'b0;
        resp_fault = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                resp_valid = 1'b1;
                resp_paddr = r_paddr;
                resp_vaddr = r_vaddr;
                resp_ci    = r_ci;
                resp_miss  = r_miss;
                resp_fault = r_fault;
            end
            default: req_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mmu_en,
    input logic              impl_present,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [ADDR_W-1:0] resp_paddr,
    input logic [ADDR_W-1:0] resp_vaddr,
    input logic              resp_ci,
    input logic              resp_miss,
    input logic              resp_fault
);
    AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid); // R9
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready); // R9
    AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !$past(mmu_en && impl_present))
            |-> (resp_paddr == resp_vaddr) && !resp_miss && !resp_fault); // R1
    AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_paddr == '0) && !resp_miss && !resp_ci); // R6
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_miss) |-> (resp_paddr == '0) && !resp_ci); // R7
endmodule

bind itlb_xlate itlb_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mmu_en       (mmu_en),
    .impl_present (impl_present),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_paddr   (resp_paddr),
    .resp_vaddr   (resp_vaddr),
    .resp_ci      (resp_ci),
    .resp_miss    (resp_miss),
    .resp_fault   (resp_fault)
);

// File: tb/itlb_xlate_test.sv
module itlb_xlate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mmu_en = 1'b1, impl_present = 1'b1, sup_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        resp_valid, resp_ci, resp_miss, resp_fault;
    logic [31:0] resp_paddr, resp_vaddr;
    logic [31:0] probe_addr = '0, probe_paddr;
    logic        reg_wr_en = 1'b0;
    logic [6:0]  reg_wr_addr = '0, reg_rd_addr = '0;
    logic [31:0] reg_wr_data = '0, reg_rd_data, cfg_info;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // captured response
    logic        c_valid, c_ci, c_miss, c_fault;
    logic [31:0] c_paddr, c_vaddr;

    always #4 clk = ~clk;

    itlb_xlate uut (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .impl_present(impl_present),
        .sup_mode(sup_mode), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_ci(resp_ci), .resp_miss(resp_miss), .resp_fault(resp_fault),
        .resp_vaddr(resp_vaddr), .probe_addr(probe_addr), .probe_paddr(probe_paddr),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .cfg_info(cfg_info)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] tag_ra(input int way, input int set);
        return {1'b0, 2'(way), 4'(set)};
    endfunction
    function automatic logic [6:0] map_ra(input int way, input int set);
        return {1'b1, 2'(way), 4'(set)};
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd_addr = a;
        #1 d = reg_rd_data;
    endtask

    task automatic fetch(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        c_valid = resp_valid; c_paddr = resp_paddr; c_ci = resp_ci;
        c_miss = resp_miss; c_fault = resp_fault; c_vaddr = resp_vaddr;
    endtask

    task automatic probe(input logic [31:0] a, output logic [31:0] p);
        @(negedge clk);
        probe_addr = a;
        #1 p = probe_paddr;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R9 ready after reset", 32'(req_ready), 1);
        chk("R9 no resp after reset", 32'(resp_valid), 0);
        rd(tag_ra(2, 3), d);  chk("R10 tag word reset", d, 0);
        rd(map_ra(1, 7), d);  chk("R10 map word reset", d, 0);
        chk("R11 geometry", cfg_info, 32'h23);
    endtask

    task automatic t_bypass();
        logic [31:0] p;
        mmu_en = 1'b0;
        fetch(32'h0042_6ABC);
        chk("R1 bypass addr", c_paddr, 32'h0042_6ABC);
        chk("R1 bypass ci low", 32'(c_ci), 0);
        chk("R1 bypass no miss", 32'(c_miss), 0);
        fetch(32'h8000_0004);
        chk("R1 bypass ci high", 32'(c_ci), 1);
        chk("R1 bypass high addr", c_paddr, 32'h8000_0004);
        mmu_en = 1'b1; impl_present = 1'b0;
        fetch(32'h7FFF_FFFC);
        chk("R1 not present addr", c_paddr, 32'h7FFF_FFFC);
        chk("R1 not present ci", 32'(c_ci), 0);
        probe(32'h1234_5678, p);
        chk("R8 probe bypass", p, 32'h1234_5678);
        impl_present = 1'b1;
    endtask

    task automatic t_hit_and_set();
        logic [31:0] d;
        wr(tag_ra(2, 3), 32'h0042_0001);
        wr(map_ra(2, 3), 32'h7700_0007);
        fetch(32'h0042_6ABC);
        chk("R9 resp valid", 32'(c_valid), 1);
        chk("R4 hit paddr", c_paddr, 32'h7700_0ABC);
        chk("R4 hit ci", 32'(c_ci), 1);
        chk("R4 hit no miss", 32'(c_miss), 0);
        rd(tag_ra(2, 3), d);
        chk("R5 hit way age reload", d, 32'h0042_03C1);
        fetch(32'h0042_8ABC);
        chk("R2 other set misses", 32'(c_miss), 1);
        fetch(32'h0044_6ABC);
        chk("R2 tag bit differs misses", 32'(c_miss), 1);
        chk("R7 miss paddr zero", c_paddr, 0);
        chk("R7 miss ci zero", 32'(c_ci), 0);
        fetch(32'h00C2_6ABC);
        chk("R2 high tag bit differs", 32'(c_miss), 1);
        rd(tag_ra(2, 3), d);
        chk("R7 miss leaves table", d, 32'h0042_03C1);
    endtask

    task automatic t_age();
        logic [31:0] d;
        logic [31:0] p;
        wr(tag_ra(0, 5), 32'h0200_0001);
        wr(tag_ra(1, 5), 32'h0300_00C1);
        wr(tag_ra(2, 5), 32'h0100_0141);
        wr(tag_ra(3, 5), 32'h0000_0040);
        wr(map_ra(2, 5), 32'h0ABC_0006);
        fetch(32'h0100_A010);
        chk("R4 hit paddr set5", c_paddr, 32'h0ABC_0010);
        chk("R4 ci clear", 32'(c_ci), 0);
        rd(tag_ra(0, 5), d); chk("R5 zero age stays", d, 32'h0200_0001);
        rd(tag_ra(1, 5), d); chk("R5 age decrement", d, 32'h0300_0081);
        rd(tag_ra(2, 5), d); chk("R5 hit way reload", d, 32'h0100_03C1);
        rd(tag_ra(3, 5), d); chk("R5 invalid way decrement", d, 32'h0000_0000);
        rd(tag_ra(2, 3), d); chk("R5 other set untouched", d, 32'h0042_03C1);
        probe(32'h0100_A010, p);
        chk("R8 probe hit", p, 32'h0ABC_0010);
        rd(tag_ra(1, 5), d); chk("R8 probe keeps age", d, 32'h0300_0081);
        probe(32'h0100_8010, p);
        chk("R8 probe miss zero", p, 0);
    endtask

    task automatic t_perm();
        logic [31:0] p;
        wr(tag_ra(0, 6), 32'h0500_0001);
        wr(map_ra(0, 6), 32'h1111_0004);
        sup_mode = 1'b1;
        fetch(32'h0500_C020);
        chk("R6 sup fault", 32'(c_fault), 1);
        chk("R6 fault paddr zero", c_paddr, 0);
        chk("R6 fault vaddr", c_vaddr, 32'h0500_C020);
        chk("R6 fault not miss", 32'(c_miss), 0);
        probe(32'h0500_C020, p);
        chk("R8 probe fault zero", p, 0);
        sup_mode = 1'b0;
        fetch(32'h0500_C020);
        chk("R6 user allowed", 32'(c_fault), 0);
        chk("R6 user paddr", c_paddr, 32'h1111_0020);
        wr(map_ra(0, 6), 32'h1111_0002);
        fetch(32'h0500_C020);
        chk("R6 user fault", 32'(c_fault), 1);
        sup_mode = 1'b1;
        fetch(32'h0500_C020);
        chk("R6 sup allowed", c_paddr, 32'h1111_0020);
        sup_mode = 1'b0;
    endtask

    task automatic t_priority();
        wr(tag_ra(1, 7), 32'h0900_0001);
        wr(map_ra(1, 7), 32'h2222_0006);
        wr(tag_ra(2, 7), 32'h0900_0001);
        wr(map_ra(2, 7), 32'h3333_0006);
        fetch(32'h0900_E100);
        chk("R3 lowest way wins", c_paddr, 32'h2222_0100);
        wr(tag_ra(1, 7), 32'h0900_0000);
        fetch(32'h0900_E100);
        chk("R3 invalid way skipped", c_paddr, 32'h3333_0100);
        wr(tag_ra(2, 7), 32'h0900_0000);
        fetch(32'h0900_E100);
        chk("R3 all invalid miss", 32'(c_miss), 1);
    endtask

    task automatic t_write_wins();
        logic [31:0] d;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h0042_6ABC;
        reg_wr_en = 1'b1; reg_wr_addr = tag_ra(2, 3); reg_wr_data = 32'h0042_0001;
        @(negedge clk);
        req_valid = 1'b0; reg_wr_en = 1'b0;
        chk("R9 resp in next cycle", 32'(resp_valid), 1);
        chk("R9 not ready while responding", 32'(req_ready), 0);
        chk("R10 lookup used old entry", resp_paddr, 32'h7700_0ABC);
        @(negedge clk);
        chk("R9 resp one cycle", 32'(resp_valid), 0);
        chk("R9 ready again", 32'(req_ready), 1);
        rd(tag_ra(2, 3), d);
        chk("R10 write beats age update", d, 32'h0042_0001);
        rd(tag_ra(3, 3), d);
        chk("R10 unwritten way", d, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_hit_and_set();
        t_age();
        t_perm();
        t_priority();
        t_write_wins();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule